// File: doc/BRIEF.md
# Selectable Program Counter Sequencer

This block is the address-sequencing core of a small 8-bit processor. It holds a file of sixteen 16-bit scratch registers. A 4-bit designator (`pc_sel`) names the register that currently serves as the program counter, and a second 4-bit designator (`ptr_sel`) names the data pointer. Every memory address the block drives comes from the register that `pc_sel` names. Software can therefore switch between several program counters at run time with a single opcode. This supports cheap subroutine and coroutine switching without a stack.

The core alternates between two machine cycles. A fetch cycle reads an opcode and steps the active register. An execute cycle acts on that opcode. The execute cycle decodes three kinds of opcode:
- in-page short branches, which read an immediate byte and test one of four external flags;
- the designator-select opcode `Dn`, which makes `Rn` the program counter;
- everything else, which is treated as a no-operation.

When interrupts are enabled, an interrupt request is honoured at the end of an execute cycle. It costs one extra cycle. During that cycle the two designators are saved into an 8-bit temporary register, and the core moves to a fixed register pair.

The controller has three states:
- `CYC_FETCH` always goes to `CYC_EXEC`.
- `CYC_EXEC` goes to `CYC_INTR` when a request is pending and interrupts are enabled. Otherwise it goes to `CYC_FETCH`.
- `CYC_INTR` always goes to `CYC_FETCH`.

Top module: `pcsel_seq`

## Requirements
- R1: After reset, `pc_sel`=0, `ptr_sel`=0, `temp`=00h and `int_en`=1, all sixteen scratch registers hold 0000h, and the core is in a fetch cycle that drives address 0000h with `mem_rd`=1.
- R2: In a fetch cycle the core drives `mem_addr` = R(`pc_sel`) with `mem_rd`=1, latches `mem_din` as the opcode and increments R(`pc_sel`) by 1.
- R3: Opcode Dh:n (high nibble D) loads `pc_sel` with the low nibble n during its execute cycle, without a memory read, so the next fetch comes from Rn; the old register keeps its value.
- R4: Opcodes 34h–37h branch when flag bit (opcode[1:0]) is 1; opcodes 3Ch–3Fh branch when that bit is 0; `flags[0]` is the first flag.
- R5: A taken short branch replaces only the low byte of R(`pc_sel`) with the immediate byte; the high byte is that of the immediate byte's own address, so a branch whose operand sits at xxFFh lands in the following page.
- R6: A short branch that is not taken leaves R(`pc_sel`) pointing one past the immediate byte.
- R7: The execute cycle of a short branch reads the immediate byte at `mem_addr` = R(`pc_sel`) with `mem_rd`=1.
- R8: Any other opcode (for example 00h or 30h) performs no memory read and changes no register or designator in its execute cycle.
- R9: With `int_en`=1 and `irq`=1 at the end of an execute cycle, the core inserts one cycle with `mem_rd`=0, then `temp` = {`ptr_sel`,`pc_sel`} (pointer designator in bits 7:4), `ptr_sel`=2, `pc_sel`=1, `int_en`=0; a request during a fetch cycle is not acted on until the following execute cycle ends.
- R10: While `int_en`=0, `irq` has no effect and fetch and execute cycles keep alternating.
- R11: Without an interrupt, fetch and execute cycles strictly alternate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq | input | 1 | Interrupt request, level sensitive |
| flags | input | 4 | External test flags for short branches |
| mem_din | input | 8 | Memory read data for the address driven in the same cycle |
| mem_addr | output | 16 | Memory address, always R(`pc_sel`) |
| mem_rd | output | 1 | Read strobe |
| pc_sel | output | 4 | Program-counter designator |
| ptr_sel | output | 4 | Data-pointer designator |
| temp | output | 8 | Designators saved on interrupt |
| int_en | output | 1 | Interrupt-enable flag |

## Verification
The hardest situation to reach from the ports is a branch whose immediate byte lies at the first address of a new page. Only then do the page of the opcode and the page of the operand differ, and R5 requires the operand's page. The bench first takes a branch to xxFFh and places a second branch opcode there. The operand of that second branch then sits at 0100h. The bench checks the landing address both with the flag set and with it clear. The interrupt entry is reached by holding `irq` from the first fetch, which also shows that the request waits for the end of an execute cycle.

// File: rtl/pcs_pkg.sv
`timescale 1ns/1ps
package pcs_pkg;
    typedef enum logic [1:0] {
        CYC_FETCH = 2'd0,
        CYC_EXEC  = 2'd1,
        CYC_INTR  = 2'd2
    } cyc_e;

    localparam logic [3:0] OPH_BRANCH = 4'h3;
    localparam logic [3:0] OPH_SELECT = 4'hD;
    localparam int         INTR_PTR   = 2;
    localparam int         INTR_PC    = 1;
endpackage

// File: rtl/pcs_regfile.sv
`timescale 1ns/1ps
module pcs_regfile #(
    parameter int NREG = 16,
    parameter int AW   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(NREG)-1:0] rd_sel,
    input  logic                    wr_en,
    input  logic [$clog2(NREG)-1:0] wr_sel,
    input  logic [AW-1:0]           wr_data,
    output logic [AW-1:0]           rd_data
);
    localparam int SW = $clog2(NREG);

    logic [AW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [SW-1:0] IDX = SW'(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && wr_sel == IDX)
                regs[g] <= wr_data;
        end
    end

    assign rd_data = regs[rd_sel];
endmodule

// File: rtl/pcs_brcond.sv
`timescale 1ns/1ps
module pcs_brcond #(
    parameter int NFLAG = 4
) (
    input  logic [7:0]       opcode,
    input  logic [NFLAG-1:0] flags,
    output logic             is_br,
    output logic             take
);
    import pcs_pkg::*;
    localparam int FW = $clog2(NFLAG);

    logic flag_val;

    always_comb begin
        is_br    = (opcode[7:4] == OPH_BRANCH) && opcode[2];
        flag_val = flags[opcode[FW-1:0]];
        // bit 3 clear: branch on flag true; bit 3 set: branch on flag false
        take     = is_br && (flag_val ^ opcode[3]);
    end
endmodule

// File: rtl/pcs_ctrl.sv
`timescale 1ns/1ps
module pcs_ctrl #(
    parameter int SW = 4,
    parameter int AW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq,
    input  logic [7:0]         mem_din,
    input  logic [AW-1:0]      pc_val,
    input  logic               is_br,
    input  logic               take,
    output logic [7:0]         opcode,
    output logic               mem_rd,
    output logic               wr_en,
    output logic [AW-1:0]      wr_data,
    output logic [SW-1:0]      p_q,
    output logic [SW-1:0]      x_q,
    output logic [2*SW-1:0]    t_q,
    output logic               ie_q,
    output pcs_pkg::cyc_e      state
);
    import pcs_pkg::*;

    cyc_e nxt;
    logic is_sel;

    assign is_sel = (opcode[7:4] == OPH_SELECT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CYC_FETCH;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = CYC_FETCH;
        unique case (state)
            CYC_FETCH: nxt = CYC_EXEC;
            CYC_EXEC:  nxt = (irq && ie_q) ? CYC_INTR : CYC_FETCH;
            CYC_INTR:  nxt = CYC_FETCH;
            default:   nxt = CYC_FETCH;
        endcase
    end

    // outputs toward memory and register file
    always_comb begin
        mem_rd  = 1'b0;
        wr_en   = 1'b0;
        wr_data = pc_val + AW'(1);
        unique case (state)
            CYC_FETCH: begin
                mem_rd = 1'b1;
                wr_en  = 1'b1;
            end
            CYC_EXEC: begin
                mem_rd = is_br;
                wr_en  = is_br;
                if (take) wr_data = {pc_val[AW-1:8], mem_din};
            end
            CYC_INTR: ;
            default: ;
        endcase
    end

    // opcode and designator registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opcode <= '0;
            p_q    <= '0;
            x_q    <= '0;
            t_q    <= '0;
            ie_q   <= 1'b1;
        end else begin
            unique case (state)
                CYC_FETCH: opcode <= mem_din;
                CYC_EXEC:  if (is_sel) p_q <= opcode[SW-1:0];
                CYC_INTR: begin
                    t_q  <= {x_q, p_q};
                    x_q  <= SW'(INTR_PTR);
                    p_q  <= SW'(INTR_PC);
                    ie_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assert_fetch_then_exec_R11: assert property (@(posedge clk) disable iff (!rst_n)
        state == CYC_FETCH |=> state == CYC_EXEC);

    assert_fetch_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state == CYC_FETCH |-> mem_rd);

    assert_select_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CYC_EXEC && is_sel) |=> p_q == $past(opcode[SW-1:0]));

    assert_intr_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        state == CYC_INTR |=> (p_q == SW'(INTR_PC) && x_q == SW'(INTR_PTR)
                               && !ie_q && t_q == $past({x_q, p_q})));

    assert_intr_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        state == CYC_INTR |-> ie_q);

    assert_other_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CYC_EXEC && !is_br && !is_sel) |=> (p_q == $past(p_q) && pc_val == $past(pc_val)));
endmodule

// File: rtl/pcsel_seq.sv
`timescale 1ns/1ps
module pcsel_seq #(
    parameter int NREG  = 16,
    parameter int AW    = 16,
    parameter int NFLAG = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      irq,
    input  logic [NFLAG-1:0]          flags,
    input  logic [7:0]                mem_din,
    output logic [AW-1:0]             mem_addr,
    output logic                      mem_rd,
    output logic [$clog2(NREG)-1:0]   pc_sel,
    output logic [$clog2(NREG)-1:0]   ptr_sel,
    output logic [2*$clog2(NREG)-1:0] temp,
    output logic                      int_en
);
    import pcs_pkg::*;
    localparam int SW = $clog2(NREG);

    logic [AW-1:0] pc_val;
    logic [AW-1:0] wr_data;
    logic          wr_en;
    logic [7:0]    opcode;
    logic          is_br;
    logic          take;
    cyc_e          state;

    pcs_regfile #(.NREG(NREG), .AW(AW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_sel  (pc_sel),
        .wr_en   (wr_en),
        .wr_sel  (pc_sel),
        .wr_data (wr_data),
        .rd_data (pc_val)
    );

    pcs_brcond #(.NFLAG(NFLAG)) u_br (
        .opcode (opcode),
        .flags  (flags),
        .is_br  (is_br),
        .take   (take)
    );

    pcs_ctrl #(.SW(SW), .AW(AW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq     (irq),
        .mem_din (mem_din),
        .pc_val  (pc_val),
        .is_br   (is_br),
        .take    (take),
        .opcode  (opcode),
        .mem_rd  (mem_rd),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .p_q     (pc_sel),
        .x_q     (ptr_sel),
        .t_q     (temp),
        .ie_q    (int_en),
        .state   (state)
    );

    assign mem_addr = pc_val;

    assert_page_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CYC_EXEC && take) |=> mem_addr[AW-1:8] == $past(mem_addr[AW-1:8]));

    assert_low_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CYC_EXEC && take) |=> mem_addr[7:0] == $past(mem_din));

    assert_skip_operand_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CYC_EXEC && is_br && !take) |=> mem_addr == $past(mem_addr) + AW'(1));
endmodule

// File: tb/pcsel_seq_tb.sv
`timescale 1ns/1ps
module pcsel_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq = 1'b0;
    logic [3:0]  flags = 4'b0;
    logic [7:0]  mem_din;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [3:0]  pc_sel;
    logic [3:0]  ptr_sel;
    logic [7:0]  temp;
    logic        int_en;

    int checks = 0;
    int errors = 0;

    logic [7:0] mem [512];
    assign mem_din = mem[mem_addr[8:0]];

    always #2 clk = ~clk;

    pcsel_seq u_dut (
        .clk(clk), .rst_n(rst_n), .irq(irq), .flags(flags), .mem_din(mem_din),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .pc_sel(pc_sel), .ptr_sel(ptr_sel),
        .temp(temp), .int_en(int_en)
    );

    // {mem_rd, pc_sel, mem_addr} per cycle after reset
    localparam logic [20:0] TRACE [27] = '{
        {1'b1, 4'h0, 16'h0000}, {1'b1, 4'h0, 16'h0001},
        {1'b1, 4'h0, 16'h0010}, {1'b1, 4'h0, 16'h0011},
        {1'b1, 4'h0, 16'h0012}, {1'b1, 4'h0, 16'h0013},
        {1'b1, 4'h0, 16'h0020}, {1'b1, 4'h0, 16'h0021},
        {1'b1, 4'h0, 16'h0022}, {1'b0, 4'h0, 16'h0023},
        {1'b1, 4'h1, 16'h0000}, {1'b1, 4'h1, 16'h0001},
        {1'b1, 4'h1, 16'h0010}, {1'b1, 4'h1, 16'h0011},
        {1'b1, 4'h1, 16'h0012}, {1'b1, 4'h1, 16'h0013},
        {1'b1, 4'h1, 16'h0020}, {1'b1, 4'h1, 16'h0021},
        {1'b1, 4'h1, 16'h0022}, {1'b0, 4'h1, 16'h0023},
        {1'b1, 4'h1, 16'h0023}, {1'b0, 4'h1, 16'h0024},
        {1'b1, 4'h0, 16'h0023}, {1'b0, 4'h0, 16'h0024},
        {1'b1, 4'h0, 16'h0024}, {1'b0, 4'h0, 16'h0025},
        {1'b1, 4'h0, 16'h0025}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    endtask

    task automatic do_reset();
        irq   = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        clear_mem();
        mem[9'h000] = 8'h34; mem[9'h001] = 8'h10;
        mem[9'h010] = 8'h35; mem[9'h011] = 8'h40;
        mem[9'h012] = 8'h3D; mem[9'h013] = 8'h20;
        mem[9'h020] = 8'h3C; mem[9'h021] = 8'h55;
        mem[9'h022] = 8'hD1; mem[9'h023] = 8'hD0;
        flags = 4'b0101;
        do_reset();
        chk("R1 reset pc_sel", 32'(pc_sel), 32'h0);
        chk("R1 reset ptr_sel", 32'(ptr_sel), 32'h0);
        chk("R1 reset temp", 32'(temp), 32'h0);
        chk("R1 reset int_en", 32'(int_en), 32'h1);
        chk("R1 reset fetch address and strobe", {15'b0, mem_rd, mem_addr}, {15'b0, 1'b1, 16'h0000});

        // Trace walk: R2 R3 R4 R6 R7 R8 R11
        for (int i = 0; i < 27; i++) begin
            chk($sformatf("trace row %0d R2 R3 R4 R6 R7 R8 R11", i),
                {11'b0, mem_rd, pc_sel, mem_addr}, {11'b0, TRACE[i]});
            step();
        end

        // R4: every flag and both polarities
        for (int f = 0; f < 2; f++) begin
            for (int k = 0; k < 8; k++) begin
                logic [7:0] op;
                logic       taken;
                logic [3:0] fp;
                fp    = (f == 0) ? 4'b0101 : 4'b1010;
                op    = (k < 4) ? (8'h34 + 8'(k)) : (8'h3C + 8'(k - 4));
                taken = (k < 4) ? fp[k % 4] : !fp[k % 4];
                clear_mem();
                mem[0] = op; mem[1] = 8'h80;
                flags = fp;
                do_reset();
                step();
                step();
                chk($sformatf("R4 flag test op=%h flags=%b", op, fp), 32'(mem_addr),
                    taken ? 32'h0080 : 32'h0002);
            end
        end

        // R5 R7: operand on the first byte of the next page, taken
        clear_mem();
        mem[9'h000] = 8'h34; mem[9'h001] = 8'hFF;
        mem[9'h0FF] = 8'h34; mem[9'h100] = 8'h30;
        flags = 4'b0001;
        do_reset();
        step(); step(); step();
        chk("R7 operand read across page", {15'b0, mem_rd, mem_addr}, {15'b0, 1'b1, 16'h0100});
        step();
        chk("R5 taken branch uses operand page", 32'(mem_addr), 32'h0130);

        // R6: same layout, not taken
        clear_mem();
        mem[9'h000] = 8'h3C; mem[9'h001] = 8'hFF;
        mem[9'h0FF] = 8'h34; mem[9'h100] = 8'h30;
        flags = 4'b0000;
        do_reset();
        step(); step(); step(); step();
        chk("R6 not-taken steps past operand", 32'(mem_addr), 32'h0101);

        // R9 R10: interrupt held from the first fetch
        clear_mem();
        mem[0] = 8'hD5;
        flags = 4'b0000;
        do_reset();
        irq = 1'b1;
        chk("R9 no entry during fetch", {15'b0, mem_rd, mem_addr}, {15'b0, 1'b1, 16'h0000});
        step();
        step();
        chk("R9 entry cycle has no read", 32'(mem_rd), 32'h0);
        chk("R3 select applied before entry", 32'(pc_sel), 32'h5);
        step();
        chk("R9 pc_sel after entry", 32'(pc_sel), 32'h1);
        chk("R9 ptr_sel after entry", 32'(ptr_sel), 32'h2);
        chk("R9 temp holds designators", 32'(temp), 32'h05);
        chk("R9 int_en cleared", 32'(int_en), 32'h0);
        chk("R9 fetch from new register", {15'b0, mem_rd, mem_addr}, {15'b0, 1'b1, 16'h0000});
        step();
        step();
        chk("R10 request ignored when disabled", {11'b0, mem_rd, pc_sel, mem_addr},
            {11'b0, 1'b1, 4'h5, 16'h0000});
        irq = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule